// File: doc/BRIEF.md
# Programmable Single-Channel DMA Controller

This block moves words between a simple synchronous memory port and a peripheral without processor involvement. Software writes a source address, a destination address and a word count into memory-mapped registers. A command register then picks the direction, the pacing mode and the address stepping, and launches the engine. In the peripheral-to-memory direction the engine acknowledges the peripheral, captures its data and writes it to memory. In the memory-to-peripheral direction it reads memory and presents the word to the peripheral with an acknowledge.

Every word follows a fixed cycle budget: one capture or read cycle, one write or present cycle, and one mandatory idle cycle. Before the first word of a block, or before each word in single mode, the engine waits for the peripheral request after it has passed through a synchronizer. When the count runs out, the engine sets a done flag and raises an interrupt. Software can also stop a run: it finishes the word in flight and reports an abort instead. Status flags are cleared by writing ones to them.

Top module: `dma_ctl`

## Requirements
- R1: After reset the engine is not busy, irq is 0, mem_req and per_ack are 0, and the status and length registers read 0.
- R2: Register map (reg_addr): 0 source, 1 destination, 2 length, 3 command, 4 status. Command bits: bit0 start, bit1 block mode, bit2 source increment, bit3 peripheral-to-memory direction, bit4 destination increment. Writing 0x08 stores the direction without starting. Writing 0x09 starts a single-mode peripheral-to-memory run with fixed addresses. Command readback returns the stored mode bits, with bit0 showing busy.
- R3: Peripheral-to-memory word: per_ack is high for one cycle, and per_rdata is captured in that cycle. In the next cycle, mem_req and mem_we are high with mem_addr equal to the destination and mem_wdata equal to the captured word.
- R4: Memory-to-peripheral word: a read (mem_req high, mem_we low) at the source address. In the next cycle, per_ack is high with per_wdata equal to the word read, and mem_addr still at the source.
- R5: When the engine is waiting and per_req rises, the first transfer cycle begins exactly SYNC_STAGES+1 rising edges after the first edge that samples the request.
- R6: In block mode, consecutive words start exactly 3 cycles apart (two transfer cycles and one idle cycle), with no further request wait.
- R7: In single mode, each word waits for the synchronized request. With per_req held high, consecutive words start 4 cycles apart.
- R8: The length register decrements once per word. The source and destination registers each advance by one per word only when their increment bit is set.
- R9: Starting with length 0 sets done and irq without any memory or peripheral access.
- R10: Status bits: bit0 busy, bit1 done, bit2 abort. Writing a 1 to done or abort clears it, and writing 0 has no effect. irq is high exactly while done or abort is set.
- R11: While busy, writes to the source, destination and length registers, and to the command mode bits, are ignored.
- R12: Writing the command register with bit0 clear while busy stops the run. The stop takes effect after the word in flight, or at once if no word has begun. It sets abort rather than done and leaves the remaining count in the length register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; data appears on reg_rdata the next cycle |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after a read request |
| per_req | input | 1 | Peripheral request, may be asynchronous |
| per_ack | output | 1 | Peripheral acknowledge, one cycle per word |
| per_rdata | input | DATA_W | Data from the peripheral |
| per_wdata | output | DATA_W | Data to the peripheral, valid with per_ack |
| irq | output | 1 | Completion or abort interrupt |

## Verification
The bench measures how many cycles pass from a request edge to the first transfer, and the spacing between words in both pacing modes. An engine that skipped the idle cycle, or that re-synchronized inside a block, would show spacing of 2 or 4 instead of 3. A zero-length start is checked for having no access at all; an engine that decrements before testing would wrap the count and run through the whole address space. The stop is checked both while the engine waits for a request and in the middle of a word. The mid-word case must leave exactly one word written and a residual count of seven, so an engine that stopped at once or ran on would show a different count or a leftover scoreboard entry. Register writes made while busy are read back to prove they were dropped.

// File: rtl/dma_pkg.sv
package dma_pkg;
  // register indices
  localparam logic [2:0] RA_SRC  = 3'd0;
  localparam logic [2:0] RA_DST  = 3'd1;
  localparam logic [2:0] RA_LEN  = 3'd2;
  localparam logic [2:0] RA_CMD  = 3'd3;
  localparam logic [2:0] RA_STAT = 3'd4;

  // command bit positions
  localparam int C_GO      = 0;
  localparam int C_BLOCK   = 1;
  localparam int C_SRC_INC = 2;
  localparam int C_TO_MEM  = 3;
  localparam int C_DST_INC = 4;

  // status bit positions
  localparam int S_BUSY  = 0;
  localparam int S_DONE  = 1;
  localparam int S_ABORT = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PH1,
    ST_PH2,
    ST_GAP
  } eng_state_t;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic req_o
);
  generate
    if (STAGES <= 1) begin : g_aligned
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= req_i;
      end
      assign req_o = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], req_i};
      end
      assign req_o = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy_i,
  input  logic          step_i,
  input  logic          fin_done_i,
  input  logic          fin_abort_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [LW-1:0] len_o,
  output logic          to_mem_o,
  output logic          block_o,
  output logic          start_o,
  output logic          stop_o,
  output logic          done_o,
  output logic          abort_o
);
  logic          cmd_wr, stat_wr;
  logic          src_inc_q, dst_inc_q;
  logic [DW-1:0] rd_mux;
  logic          unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign cmd_wr  = reg_we && (reg_addr == RA_CMD);
  assign stat_wr = reg_we && (reg_addr == RA_STAT);
  assign start_o = cmd_wr && reg_wdata[C_GO] && !busy_i;
  assign stop_o  = cmd_wr && !reg_wdata[C_GO] && busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_o     <= '0;
      dst_o     <= '0;
      len_o     <= '0;
      to_mem_o  <= 1'b0;
      block_o   <= 1'b0;
      src_inc_q <= 1'b0;
      dst_inc_q <= 1'b0;
      done_o    <= 1'b0;
      abort_o   <= 1'b0;
    end else begin
      if (reg_we && !busy_i) begin
        case (reg_addr)
          RA_SRC: src_o <= reg_wdata[AW-1:0];
          RA_DST: dst_o <= reg_wdata[AW-1:0];
          RA_LEN: len_o <= reg_wdata[LW-1:0];
          RA_CMD: begin
            block_o   <= reg_wdata[C_BLOCK];
            src_inc_q <= reg_wdata[C_SRC_INC];
            to_mem_o  <= reg_wdata[C_TO_MEM];
            dst_inc_q <= reg_wdata[C_DST_INC];
          end
          default: ;
        endcase
      end
      if (step_i) begin
        len_o <= len_o - LW'(1);
        if (src_inc_q) src_o <= src_o + AW'(1);
        if (dst_inc_q) dst_o <= dst_o + AW'(1);
      end
      if (fin_done_i)                         done_o  <= 1'b1;
      else if (stat_wr && reg_wdata[S_DONE])  done_o  <= 1'b0;
      if (fin_abort_i)                        abort_o <= 1'b1;
      else if (stat_wr && reg_wdata[S_ABORT]) abort_o <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_SRC: rd_mux = DW'(src_o);
      RA_DST: rd_mux = DW'(dst_o);
      RA_LEN: rd_mux = DW'(len_o);
      RA_CMD: begin
        rd_mux[C_GO]      = busy_i;
        rd_mux[C_BLOCK]   = block_o;
        rd_mux[C_SRC_INC] = src_inc_q;
        rd_mux[C_TO_MEM]  = to_mem_o;
        rd_mux[C_DST_INC] = dst_inc_q;
      end
      RA_STAT: begin
        rd_mux[S_BUSY]  = busy_i;
        rd_mux[S_DONE]  = done_o;
        rd_mux[S_ABORT] = abort_o;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          req_i,
  input  logic [LW-1:0] len_i,
  input  logic          to_mem_i,
  input  logic          block_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [DW-1:0] per_rdata_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          step_o,
  output logic          fin_done_o,
  output logic          fin_abort_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          per_ack_o,
  output logic [DW-1:0] per_wdata_o
);
  eng_state_t    st;
  logic          stop_pend, stop_now, len_zero;
  logic [DW-1:0] data_q;

  assign stop_now = stop_pend | stop_i;
  assign len_zero = (len_i == '0);

  assign fin_done_o  = ((st == ST_IDLE) && start_i && len_zero) ||
                       ((st == ST_GAP) && len_zero);
  assign fin_abort_o = ((st == ST_WAIT) && stop_now) ||
                       ((st == ST_GAP) && !len_zero && stop_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      stop_pend <= 1'b0;
      data_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start_i && !len_zero) st <= ST_WAIT;
        ST_WAIT: begin
          if (stop_now)   st <= ST_IDLE;
          else if (req_i) st <= ST_PH1;
        end
        ST_PH1:  st <= ST_PH2;
        ST_PH2:  st <= ST_GAP;
        ST_GAP: begin
          if (len_zero || stop_now) st <= ST_IDLE;
          else if (block_i)         st <= ST_PH1;
          else                      st <= ST_WAIT;
        end
        default: st <= ST_IDLE;
      endcase
      if (st == ST_IDLE) stop_pend <= 1'b0;
      else if (stop_i)   stop_pend <= 1'b1;
      if (st == ST_PH1 && to_mem_i) data_q <= per_rdata_i;
    end
  end

  assign busy_o      = (st != ST_IDLE);
  assign step_o      = (st == ST_PH2);
  assign mem_req_o   = ((st == ST_PH1) && !to_mem_i) || ((st == ST_PH2) && to_mem_i);
  assign mem_we_o    = (st == ST_PH2) && to_mem_i;
  assign mem_addr_o  = to_mem_i ? dst_i : src_i;
  assign mem_wdata_o = data_q;
  assign per_ack_o   = ((st == ST_PH1) && to_mem_i) || ((st == ST_PH2) && !to_mem_i);
  assign per_wdata_o = mem_rdata_i;
endmodule

// File: rtl/dma_ctl.sv
module dma_ctl #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              per_req,
  output logic              per_ack,
  input  logic [DATA_W-1:0] per_rdata,
  output logic [DATA_W-1:0] per_wdata,
  output logic              irq
);
  logic              req_s, busy, step, fin_done, fin_abort;
  logic              to_mem, block, start, stop, done_f, abort_f;
  logic [ADDR_W-1:0] src, dst;
  logic [LEN_W-1:0]  len;

  dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .req_i(per_req), .req_o(req_s)
  );

  dma_regs #(.AW(ADDR_W), .DW(DATA_W), .LW(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy_i(busy), .step_i(step), .fin_done_i(fin_done), .fin_abort_i(fin_abort),
    .src_o(src), .dst_o(dst), .len_o(len), .to_mem_o(to_mem), .block_o(block),
    .start_o(start), .stop_o(stop), .done_o(done_f), .abort_o(abort_f)
  );

  dma_engine #(.AW(ADDR_W), .DW(DATA_W), .LW(LEN_W)) u_eng (
    .clk(clk), .rst(rst), .start_i(start), .stop_i(stop), .req_i(req_s),
    .len_i(len), .to_mem_i(to_mem), .block_i(block), .src_i(src), .dst_i(dst),
    .per_rdata_i(per_rdata), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .step_o(step), .fin_done_o(fin_done), .fin_abort_o(fin_abort),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .per_ack_o(per_ack), .per_wdata_o(per_wdata)
  );

  assign irq = done_f | abort_f;
endmodule

// File: rtl/dma_ctl_chk.sv
module dma_ctl_chk (
  input logic clk,
  input logic rst,
  input logic mem_req,
  input logic mem_we,
  input logic per_ack,
  input logic irq
);
  // R3/R4: memory and peripheral never served in the same cycle
  assert_one_side_R3: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && per_ack));

  // R3: a memory write always follows a peripheral capture cycle
  assert_write_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(per_ack));

  // R4: a memory read is followed by the peripheral acknowledge
  assert_ack_after_read_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> per_ack);

  // R6: the cycle after a word's second phase is idle
  assert_idle_after_word_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_we || (per_ack && $past(mem_req && !mem_we))) |=> !(mem_req || per_ack));

  // R10: the interrupt rises only once the engine is quiet
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !(mem_req || per_ack));
endmodule

bind dma_ctl dma_ctl_chk u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .per_ack(per_ack), .irq(irq)
);

// File: tb/sim_dma_ctl.sv
`timescale 1ns/1ps
module sim_dma_ctl;
  localparam int SYNC = 2;
  localparam logic [2:0] A_SRC = 3'd0, A_DST = 3'd1, A_LEN = 3'd2, A_CMD = 3'd3, A_STAT = 3'd4;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, per_ack, irq;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, per_rdata, per_wdata;
  logic        per_req = 1'b0;

  dma_ctl #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .per_req(per_req), .per_ack(per_ack), .per_rdata(per_rdata),
    .per_wdata(per_wdata), .irq(irq)
  );

  always #10 clk = ~clk;  // 50 MHz

  int   cyc = 0, nst = 0, ev_cnt = 0, pcnt = 0, n_cmp = 0, n_bad = 0;
  int   st_cyc [0:63];
  logic cur_to_mem = 1'b0;
  logic finished = 1'b0;

  typedef struct packed { logic [15:0] a; logic [31:0] d; } item_t;
  item_t sbq[$];
  item_t it;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: one-cycle read latency, A000_0000+addr after reset
  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA000_0000 + 32'(i);
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
    if (!rst && per_ack && cur_to_mem) pcnt <= pcnt + 1;
  end
  assign per_rdata = 32'hC000_0000 + 32'(pcnt);

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (!rst) begin
      if ((per_ack && cur_to_mem) || (mem_req && !mem_we)) begin
        if (nst < 64) st_cyc[nst] = cyc;
        nst++;
      end
      if ((mem_req && mem_we) || (per_ack && !cur_to_mem)) begin
        ev_cnt++;
        if (sbq.size() == 0) chk("R3/R4 unexpected transfer", 32'(mem_addr), 32'hFFFF_FFFF);
        else begin
          it = sbq.pop_front();
          chk("R3/R4/R8 transfer address", 32'(mem_addr), 32'(it.a));
          chk("R3/R4 transfer data", mem_we ? mem_wdata : per_wdata, it.d);
        end
      end
      if (per_ack && cur_to_mem) ev_cnt++;
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n = 0;
    do begin reg_rd(A_STAT, v); n++; end while (v[0] && n < 500);
    chk("R10 run ends (busy bit)", 32'(v[0]), 32'd0);
  endtask

  task automatic push(input logic [15:0] a, input logic [31:0] d);
    sbq.push_back('{a: a, d: d});
  endtask

  initial begin
    logic [31:0] v;
    int n0, e0, rc;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 per_ack", 32'(per_ack), 0);
    reg_rd(A_STAT, v); chk("R1 status", v, 0);
    reg_rd(A_LEN, v);  chk("R1 length", v, 0);

    // R2: 0x08 selects direction only
    e0 = ev_cnt;
    reg_wr(A_CMD, 32'h08);
    repeat (3) @(negedge clk);
    reg_rd(A_STAT, v); chk("R2 0x08 does not start", v, 0);
    reg_rd(A_CMD, v);  chk("R2 command readback", v, 32'h08);
    chk("R2 no activity after 0x08", ev_cnt, e0);

    // R2/R3: 0x09 single mode, fixed destination
    reg_wr(A_DST, 32'h20); reg_wr(A_LEN, 32'd2);
    cur_to_mem = 1'b1;
    push(16'h20, 32'hC000_0000 + 32'(pcnt));
    push(16'h20, 32'hC000_0000 + 32'(pcnt + 1));
    reg_wr(A_CMD, 32'h09);
    per_req = 1'b1;
    wait_idle();
    per_req = 1'b0;
    chk("R3 all words written", sbq.size(), 0);
    reg_rd(A_STAT, v); chk("R10 done flag", v, 32'h2);
    chk("R10 irq with done", 32'(irq), 1);
    reg_rd(A_LEN, v);  chk("R8 length at end", v, 0);
    reg_rd(A_DST, v);  chk("R2 fixed destination", v, 32'h20);
    reg_wr(A_STAT, 32'h0);
    reg_rd(A_STAT, v); chk("R10 writing zero keeps done", v, 32'h2);
    reg_wr(A_STAT, 32'h2);
    reg_rd(A_STAT, v); chk("R10 write-one clears done", v, 0);
    chk("R10 irq cleared", 32'(irq), 0);

    // R5/R6/R8: block, peripheral to memory, incrementing destination
    reg_wr(A_DST, 32'h40); reg_wr(A_LEN, 32'd4);
    for (int k = 0; k < 4; k++) push(16'h40 + 16'(k), 32'hC000_0000 + 32'(pcnt + k));
    reg_wr(A_CMD, 32'h1B);
    n0 = nst;
    repeat (4) @(negedge clk);
    per_req = 1'b1; rc = cyc;
    wait_idle();
    per_req = 1'b0;
    chk("R5 request to first transfer", st_cyc[n0] - rc, SYNC + 1);
    for (int k = 0; k < 3; k++)
      chk("R6 block word spacing", st_cyc[n0 + k + 1] - st_cyc[n0 + k], 3);
    reg_rd(A_DST, v); chk("R8 destination advanced", v, 32'h44);
    chk("R3 block words written", sbq.size(), 0);
    reg_wr(A_STAT, 32'h2);

    // R4/R8: block, memory to peripheral, incrementing source
    cur_to_mem = 1'b0;
    reg_wr(A_SRC, 32'h10); reg_wr(A_LEN, 32'd3);
    for (int k = 0; k < 3; k++) push(16'h10 + 16'(k), 32'hA000_0010 + 32'(k));
    reg_wr(A_CMD, 32'h07);
    per_req = 1'b1;
    wait_idle();
    per_req = 1'b0;
    chk("R4 all words delivered", sbq.size(), 0);
    reg_rd(A_SRC, v); chk("R8 source advanced", v, 32'h13);
    reg_wr(A_STAT, 32'h2);

    // R7: single mode with request held high
    reg_wr(A_SRC, 32'h30); reg_wr(A_LEN, 32'd3);
    for (int k = 0; k < 3; k++) push(16'h30 + 16'(k), 32'hA000_0030 + 32'(k));
    per_req = 1'b1;
    n0 = nst;
    reg_wr(A_CMD, 32'h05);
    wait_idle();
    per_req = 1'b0;
    for (int k = 0; k < 2; k++)
      chk("R7 single word spacing", st_cyc[n0 + k + 1] - st_cyc[n0 + k], 4);
    chk("R7 words delivered", sbq.size(), 0);
    reg_wr(A_STAT, 32'h2);

    // R9: zero length
    reg_wr(A_LEN, 32'd0);
    e0 = ev_cnt;
    reg_wr(A_CMD, 32'h09);
    repeat (3) @(negedge clk);
    reg_rd(A_STAT, v); chk("R9 zero length done", v, 32'h2);
    chk("R9 irq", 32'(irq), 1);
    chk("R9 no access", ev_cnt, e0);
    reg_wr(A_STAT, 32'h2);

    // R11/R12: writes while busy, stop while waiting
    cur_to_mem = 1'b1;
    reg_wr(A_DST, 32'h50); reg_wr(A_LEN, 32'd5);
    reg_wr(A_CMD, 32'h1B);
    e0 = ev_cnt;
    reg_wr(A_SRC, 32'h77); reg_wr(A_DST, 32'h66); reg_wr(A_LEN, 32'd9);
    reg_wr(A_CMD, 32'h01);
    reg_rd(A_SRC, v); chk("R11 source write ignored", v, 32'h33);
    reg_rd(A_DST, v); chk("R11 destination write ignored", v, 32'h50);
    reg_rd(A_LEN, v); chk("R11 length write ignored", v, 32'd5);
    reg_rd(A_CMD, v); chk("R11 mode bits kept, busy shown", v, 32'h1B);
    reg_wr(A_CMD, 32'h00);
    reg_rd(A_STAT, v); chk("R12 abort while waiting", v, 32'h4);
    chk("R12 irq on abort", 32'(irq), 1);
    chk("R12 no access on early stop", ev_cnt, e0);
    reg_wr(A_STAT, 32'h4);
    reg_rd(A_STAT, v); chk("R10 write-one clears abort", v, 0);

    // R12: stop during the first word of a block
    reg_wr(A_DST, 32'h60); reg_wr(A_LEN, 32'd8);
    push(16'h60, 32'hC000_0000 + 32'(pcnt));
    reg_wr(A_CMD, 32'h1B);
    per_req = 1'b1;
    wait (per_ack === 1'b1);
    @(negedge clk); reg_we = 1'b1; reg_addr = A_CMD; reg_wdata = 32'h0;
    @(negedge clk); reg_we = 1'b0;
    wait_idle();
    per_req = 1'b0;
    chk("R12 only word in flight written", sbq.size(), 0);
    reg_rd(A_STAT, v); chk("R12 abort not done", v, 32'h4);
    reg_rd(A_LEN, v);  chk("R12 remaining count", v, 32'd7);
    reg_rd(A_DST, v);  chk("R12 destination after one word", v, 32'h61);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule